// File: doc/BRIEF.md
# Dual-Rate Serial IO Expander Link

This block carries a large set of slow parallel IO signals across a handful of fast serial wires. It runs between a main logic device and a companion IO expander. Both ends of the link sit in one top module. The sending half turns each group's parallel word into one bit per fast clock on each wire, and exposes the serial wires and frame strobes as outputs. The receiving half follows those same wires and strobes and rebuilds the parallel outputs.

There are two IO groups, and both are timed from one shared fast bit clock. At a 28 MHz bit clock, the short group uses 8-slot frames, so its IO refreshes at 3.5 MHz. This group suits sound and video-class outputs. The long group uses 20-slot frames, so its IO refreshes at 1.4 MHz. This group suits peripheral-adapter outputs, and the rate also covers a slower 700 kHz legacy need. The number of wires in each group is a parameter.

For each group, the sender takes a snapshot of its parallel input once per frame. It then sends that word LSB first. The receiver collects the bits in a staging register. It moves them to its output register only at the end of the frame, so the outputs never show a half-finished word.

Top module: `iox_link`

## Requirements
- R1: Each group's frame strobe (`short_sync`, `long_sync`) is high for exactly one cycle, in slot 0 of every frame. This repeats every 8 cycles for the short group and every 20 cycles for the long group. The first strobe comes one full frame (8 or 20 cycles) after reset is released.
- R2: During slot k of a frame, serial wire w of a group carries bit w*SLOTS+k of the word that the sender captured for that frame. Bits go out LSB first, slot 0 first.
- R3: The sender captures the whole input word of a group on the clock edge that ends the last slot (slot SLOTS-1) of the previous frame. Input changes at any other time in a frame have no effect on the bits sent in that frame.
- R4: A group's parallel output changes only on the edge that ends the last slot of a frame. It holds its value through every other cycle.
- R5: During reset, all serial wires, frame strobes and parallel outputs are 0. After reset, each group's outputs stay 0 until the first complete frame has been received.
- R6: At the receiver, slot k of short wire w lands on `short_dout` bit w*8+k. The whole input word captured before frame F appears on `short_dout` from slot 0 of frame F+1.
- R7: The long group behaves the same way with 20-slot frames (bit w*20+k). It runs independently of the short group, even though both share one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock shared by both groups |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_din | input | SHORT_WIRES*SHORT_SLOTS | Parallel word for the short-frame group |
| long_din | input | LONG_WIRES*LONG_SLOTS | Parallel word for the long-frame group |
| short_line | output | SHORT_WIRES | Serial wires of the short-frame group |
| long_line | output | LONG_WIRES | Serial wires of the long-frame group |
| short_sync | output | 1 | Frame strobe of the short group, high in slot 0 |
| long_sync | output | 1 | Frame strobe of the long group, high in slot 0 |
| short_dout | output | SHORT_WIRES*SHORT_SLOTS | Rebuilt parallel outputs of the short group |
| long_dout | output | LONG_WIRES*LONG_SLOTS | Rebuilt parallel outputs of the long group |

## Verification
The assertions check the following on every cycle:
- a strobe always follows the last slot;
- the strobe never lasts two cycles;
- the LSB goes out right after capture;
- the outputs move only after a frame's last slot;
- the receiver's frame position stays in lockstep with the sender's;
- the outputs stay zero until lock.

Only the bench's scenarios can show the rest. It checks that each bit lands at the right slot and output position under random and extreme words. It also changes the inputs mid-frame to show they are ignored. Finally, it checks the exact one-frame latency on both groups at their different periods.

// File: rtl/iox_pkg.sv
package iox_pkg;
   localparam int unsigned IOX_SHORT_SLOTS = 8;
   localparam int unsigned IOX_LONG_SLOTS  = 20;

   // Width of a slot index for a frame of n slots (at least one bit).
   function automatic int unsigned iox_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/iox_frame_timer.sv
// Sender-side slot counter: marks the last slot and raises the frame strobe
// in slot 0 once the first snapshot has been taken.
module iox_frame_timer #(
   parameter int unsigned SLOTS = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic last_o,
   output logic sync_o
);
   localparam int unsigned IW = iox_pkg::iox_idx_w(SLOTS);
   localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

   if (SLOTS < 2) begin : g_bad_slots
      $error("iox_frame_timer: SLOTS must be at least 2");
   end

   logic [IW-1:0] cnt;
   logic          primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         primed <= 1'b0;
      end else if (cnt == LAST) begin
         cnt    <= '0;
         primed <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign last_o = (cnt == LAST);
   assign sync_o = primed && (cnt == '0);

   AST_WRAP_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> sync_o);                                        // R1
   AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o);                                       // R1
endmodule

// File: rtl/iox_frame_track.sv
// Receiver-side slot tracker: locks to the frame strobe and reports the
// current slot and the last slot of each locked frame.
module iox_frame_track #(
   parameter int unsigned SLOTS = 8,
   parameter int unsigned IW    = iox_pkg::iox_idx_w(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_i,
   output logic [IW-1:0] slot_o,
   output logic          last_o,
   output logic          locked_o
);
   localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

   logic [IW-1:0] rcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt     <= '0;
         locked_o <= 1'b0;
      end else if (sync_i) begin
         rcnt     <= IW'(1);
         locked_o <= 1'b1;
      end else if (rcnt == LAST) begin
         rcnt <= '0;
      end else begin
         rcnt <= rcnt + 1'b1;
      end
   end

   assign slot_o = sync_i ? '0 : rcnt;
   assign last_o = locked_o && (slot_o == LAST);
endmodule

// File: rtl/iox_ser_lane.sv
// One serial wire: loads a full snapshot at the frame boundary and shifts
// it out LSB first.
module iox_ser_lane #(
   parameter int unsigned SLOTS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             last_i,
   input  logic [SLOTS-1:0] din_i,
   output logic             line_o
);
   logic [SLOTS-2:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_o <= 1'b0;
         hold   <= '0;
      end else if (last_i) begin
         line_o <= din_i[0];
         hold   <= din_i[SLOTS-1:1];
      end else begin
         line_o <= hold[0];
         hold   <= hold >> 1;
      end
   end

   AST_LSB_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      last_i |=> (line_o == $past(din_i[0])));                   // R2
endmodule

// File: rtl/iox_des_lane.sv
// One receive wire: stages bits by slot and publishes the whole word at the
// end of the frame.
module iox_des_lane #(
   parameter int unsigned SLOTS = 8,
   parameter int unsigned IW    = iox_pkg::iox_idx_w(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    slot_i,
   input  logic             last_i,
   input  logic             line_i,
   output logic [SLOTS-1:0] dout_o
);
   localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

   logic [SLOTS-2:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage  <= '0;
         dout_o <= '0;
      end else if (last_i) begin
         dout_o <= {line_i, stage};
      end else if (slot_i < LAST) begin
         stage[slot_i] <= line_i;
      end
   end

   AST_OUT_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_o) |-> $past(last_i));                       // R4
endmodule

// File: rtl/iox_group.sv
// One IO group: sender timer and lanes, receiver tracker and lanes.
module iox_group #(
   parameter int unsigned WIRES = 2,
   parameter int unsigned SLOTS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIRES*SLOTS-1:0] din_i,
   output logic [WIRES-1:0]       line_o,
   output logic                   sync_o,
   output logic [WIRES*SLOTS-1:0] dout_o
);
   localparam int unsigned IW = iox_pkg::iox_idx_w(SLOTS);

   if (WIRES < 1) begin : g_bad_wires
      $error("iox_group: WIRES must be at least 1");
   end

   logic          tx_last;
   logic [IW-1:0] rx_slot;
   logic          rx_last;
   logic          rx_locked;

   iox_frame_timer #(.SLOTS(SLOTS)) u_timer (
      .clk(clk), .rst_n(rst_n), .last_o(tx_last), .sync_o(sync_o));

   iox_frame_track #(.SLOTS(SLOTS), .IW(IW)) u_track (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_o),
      .slot_o(rx_slot), .last_o(rx_last), .locked_o(rx_locked));

   for (genvar w = 0; w < WIRES; w++) begin : g_lane
      iox_ser_lane #(.SLOTS(SLOTS)) u_ser (
         .clk(clk), .rst_n(rst_n), .last_i(tx_last),
         .din_i(din_i[w*SLOTS +: SLOTS]), .line_o(line_o[w]));

      iox_des_lane #(.SLOTS(SLOTS), .IW(IW)) u_des (
         .clk(clk), .rst_n(rst_n), .slot_i(rx_slot), .last_i(rx_last),
         .line_i(line_o[w]), .dout_o(dout_o[w*SLOTS +: SLOTS]));
   end

   AST_RX_TX_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_locked |-> (rx_last == tx_last));                       // R6
   AST_ZERO_UNTIL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_locked |-> (dout_o == '0));                            // R5
endmodule

// File: rtl/iox_link.sv
// Dual-rate serial IO expander link: a short-frame and a long-frame group
// sharing one fast bit clock.
module iox_link #(
   parameter int unsigned SHORT_WIRES = 2,
   parameter int unsigned LONG_WIRES  = 3,
   parameter int unsigned SHORT_SLOTS = iox_pkg::IOX_SHORT_SLOTS,
   parameter int unsigned LONG_SLOTS  = iox_pkg::IOX_LONG_SLOTS,
   localparam int unsigned SW = SHORT_WIRES * SHORT_SLOTS,
   localparam int unsigned LW = LONG_WIRES * LONG_SLOTS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SW-1:0]          short_din,
   input  logic [LW-1:0]          long_din,
   output logic [SHORT_WIRES-1:0] short_line,
   output logic [LONG_WIRES-1:0]  long_line,
   output logic                   short_sync,
   output logic                   long_sync,
   output logic [SW-1:0]          short_dout,
   output logic [LW-1:0]          long_dout
);
   if (SHORT_SLOTS >= LONG_SLOTS) begin : g_bad_order
      $error("iox_link: short frames must be shorter than long frames");
   end

   iox_group #(.WIRES(SHORT_WIRES), .SLOTS(SHORT_SLOTS)) u_short (
      .clk(clk), .rst_n(rst_n), .din_i(short_din),
      .line_o(short_line), .sync_o(short_sync), .dout_o(short_dout));

   iox_group #(.WIRES(LONG_WIRES), .SLOTS(LONG_SLOTS)) u_long (
      .clk(clk), .rst_n(rst_n), .din_i(long_din),
      .line_o(long_line), .sync_o(long_sync), .dout_o(long_dout));
endmodule

// File: tb/iox_link_tb.sv
module iox_link_tb;
   localparam int SWI = 2;
   localparam int LWI = 3;
   localparam int SL  = 8;
   localparam int LL  = 20;
   localparam int SWD = SWI * SL;
   localparam int LWD = LWI * LL;
   localparam logic [63:0] SMASK = (64'd1 << SWD) - 64'd1;
   localparam logic [63:0] LMASK = (64'd1 << LWD) - 64'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [63:0] s_din = '0;
   logic [63:0] l_din = '0;
   logic [SWI-1:0] short_line;
   logic [LWI-1:0] long_line;
   logic short_sync, long_sync;
   logic [SWD-1:0] short_dout;
   logic [LWD-1:0] long_dout;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   iox_link #(.SHORT_WIRES(SWI), .LONG_WIRES(LWI),
              .SHORT_SLOTS(SL), .LONG_SLOTS(LL)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .short_din(s_din[SWD-1:0]), .long_din(l_din[LWD-1:0]),
      .short_line(short_line), .long_line(long_line),
      .short_sync(short_sync), .long_sync(long_sync),
      .short_dout(short_dout), .long_dout(long_dout));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Directed corner words for the first frames, random afterwards.
   function automatic logic [63:0] gen(input int fr, input logic [63:0] mask);
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      case (fr)
         1: r = '1;
         2: r = '0;
         3: r = 64'h5555_5555_5555_5555;
         4: r = 64'hAAAA_AAAA_AAAA_AAAA;
         5: r = 64'h1;
         default: ;
      endcase
      return r & mask;
   endfunction

   initial begin
      logic [63:0] s_p1, s_p2, s_tx, s_hold;
      logic [63:0] l_p1, l_p2, l_tx, l_hold;
      int s_cnt, s_slot, s_fr, l_cnt, l_slot, l_fr;
      bit s_seen, l_seen;
      void'($urandom(32'd2718));
      s_p1 = gen(0, SMASK); l_p1 = gen(0, LMASK);
      s_p2 = '0; l_p2 = '0; s_tx = '0; l_tx = '0; s_hold = '0; l_hold = '0;
      s_cnt = 0; s_slot = 0; s_fr = 0; l_cnt = 0; l_slot = 0; l_fr = 0;
      s_seen = 1'b0; l_seen = 1'b0;
      s_din = s_p1; l_din = l_p1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R5: reset state
      chk("R5 reset sdout", 64'(short_dout), '0);
      chk("R5 reset ldout", 64'(long_dout), '0);
      chk("R5 reset lines", 64'({short_line, long_line}), '0);
      chk("R5 reset syncs", 64'({short_sync, long_sync}), '0);
      rst_n = 1'b1;
      while (l_fr < 40) begin
         @(negedge clk);
         // ---------------- short group ----------------
         s_cnt++;
         if (short_sync) begin
            chk("R1 short period", 64'(s_cnt), 64'(SL));
            s_cnt = 0;
            s_tx = s_p1;
            if (s_seen) chk("R6 short dout", 64'(short_dout), s_p2);
            else        chk("R5 short first", 64'(short_dout), '0);
            s_hold = s_p2; s_p2 = s_p1;
            s_fr++;
            s_p1 = gen(s_fr, SMASK); s_din = s_p1;
            s_slot = 0; s_seen = 1'b1;
         end else if (s_seen) begin
            s_slot++;
         end
         if (!s_seen) begin
            chk("R5 short idle", 64'({short_line, short_dout}), '0);
         end else begin
            for (int w = 0; w < SWI; w++)
               chk("R2 short slot bit", 64'(short_line[w]), 64'(s_tx[w*SL+s_slot]));
            if (!short_sync) chk("R4 short hold", 64'(short_dout), s_hold);
            if (s_fr[0] && s_slot == 3)    s_din = ~s_p1 & SMASK;   // R3 mid-frame noise
            if (s_fr[0] && s_slot == SL-2) s_din = s_p1;
         end
         // ---------------- long group ----------------
         l_cnt++;
         if (long_sync) begin
            chk("R1 long period", 64'(l_cnt), 64'(LL));
            l_cnt = 0;
            l_tx = l_p1;
            if (l_seen) chk("R7 long dout", 64'(long_dout), l_p2);
            else        chk("R5 long first", 64'(long_dout), '0);
            l_hold = l_p2; l_p2 = l_p1;
            l_fr++;
            l_p1 = gen(l_fr, LMASK); l_din = l_p1;
            l_slot = 0; l_seen = 1'b1;
         end else if (l_seen) begin
            l_slot++;
         end
         if (!l_seen) begin
            chk("R5 long idle", 64'({long_line, long_dout}), '0);
         end else begin
            for (int w = 0; w < LWI; w++)
               chk("R2 long slot bit", 64'(long_line[w]), 64'(l_tx[w*LL+l_slot]));
            if (!long_sync) chk("R4 long hold", 64'(long_dout), l_hold);
            if (l_fr[0] && l_slot == 5)    l_din = ~l_p1 & LMASK;   // R3 mid-frame noise
            if (l_fr[0] && l_slot == LL-2) l_din = l_p1;
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule